// File: doc/BRIEF.md
# Masked Four-Lane Vector Arithmetic Unit

This unit runs one element-wise vector operation at a time over 32-bit elements. The elements are dealt out to four lanes in rotation: element i goes to lane i mod 4. All four lanes work on one group of four consecutive elements per cycle, so a vector of N elements takes about N/4 cycles. A caller starts an operation with an opcode, a vector length, a scalar operand and a mask-mode flag. The unit then walks through the element groups. It reads both source vectors one group at a time from external storage that has one cycle of read latency. It returns results one group at a time on a write port that has one enable bit per element.

The unit can add, subtract and multiply, either vector with vector or vector with a broadcast scalar. It holds a 64-bit per-element mask. A not-equal compare updates that mask and writes no data. In masked mode, an arithmetic operation writes only those elements whose mask bit is set. Elements at or beyond the vector length are never touched. Lanes never exchange data.

Top module: `vec_lane_alu`

## Requirements
- R1: After reset, `wr_en`, `rd_en` and `done` are 0 and every bit of `mask_o` is 1.
- R2: Element i is carried by lane i mod 4 of group i/4. On both ports, lane l occupies bits [32l+31:32l] and `wr_be[l]`.
- R3: An operation with VL > 0 produces its ceil(VL/4) group writes on consecutive cycles. `done` is high for one cycle, together with the last write, ceil(VL/4)+1 cycles after the clock edge that accepts `start`. With VL = 0, `done` is high on the cycle right after the accepting edge.
- R4: Only elements 0 to VL-1 can be enabled. A VL above 64 is treated as 64. VL = 0 produces no write.
- R5: The opcode is decoded as follows. `op[2:1]` = 00 is add, 01 is subtract (A minus second operand), 10 is multiply and 11 is not-equal compare. Add, subtract and multiply keep the low 32 bits of the result.
- R6: `op[0]` = 1 selects the scalar form: `scalar` replaces the B element for every element.
- R7: A compare sets mask bit i to (A[i] != second operand) for each i < VL. Mask bits at or beyond VL keep their values. A compare asserts no `wr_en` and ignores mask mode.
- R8: With `use_mask` = 1, an arithmetic element i < VL is enabled only when mask bit i is 1. With `use_mask` = 0, all elements below VL are enabled. Disabled elements keep their old destination values.
- R9: Reads are requested with `rd_en` for groups 0, 1, … , ceil(VL/4)-1 on consecutive cycles. `rd_a`/`rd_b` must carry the addressed group in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; ignored while one is in flight |
| op | input | 3 | Opcode: function in [2:1], scalar form in [0] |
| vl | input | 7 | Vector length in elements |
| scalar | input | 32 | Scalar operand |
| use_mask | input | 1 | 1 = gate element writes by the mask |
| rd_en | output | 1 | Source read request |
| rd_grp | output | 4 | Element group being read |
| rd_a | input | 128 | Four A elements of the group requested last cycle |
| rd_b | input | 128 | Four B elements of the group requested last cycle |
| wr_en | output | 1 | Result group valid |
| wr_grp | output | 4 | Destination element group |
| wr_data | output | 128 | Four result elements |
| wr_be | output | 4 | Per-element write enables |
| mask_o | output | 64 | Current mask register |
| done | output | 1 | Operation finished |

## Verification
The bench sweeps every opcode in both mask modes over vector lengths 0, 1, 3, 4, 5, 63, 64 and 100. This hits empty, partial-group, exact-group, full and over-length vectors. A unit that mishandled a partial last group would write lanes past VL or drop the final elements. A unit that did not clamp the length would run past 16 groups. Compares are placed between masked arithmetic runs, and the source data makes some elements equal. A wrong mask update, or a mask gate that ignores the mode, therefore shows up as clobbered sentinel values or missing results. Checks on the cycle count and on the number of writes catch an off-by-one group count or a gap in the stream.

// File: rtl/vlalu_pkg.sv
package vlalu_pkg;
  typedef enum logic [1:0] {
    FN_ADD = 2'd0,
    FN_SUB = 2'd1,
    FN_MUL = 2'd2,
    FN_CNE = 2'd3
  } fn_e;
endpackage

// File: rtl/vlalu_seq.sv
// Group sequencer: issues source reads and tracks the one-deep compute stage.
module vlalu_seq #(
  parameter int LANES = 4,
  parameter int MAXVL = 64,
  localparam int NG = MAXVL / LANES,
  localparam int GW = (NG > 1) ? $clog2(NG) : 1,
  localparam int LB = $clog2(LANES),
  localparam int VW = $clog2(MAXVL + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [VW-1:0] vl,
  output logic          accept,
  output logic          zero_acc,
  output logic [VW-1:0] vl_q,
  output logic          rd_en,
  output logic [GW-1:0] rd_grp,
  output logic          s1_vld,
  output logic [GW-1:0] s1_grp,
  output logic          s1_last
);
  logic          busy;
  logic [GW-1:0] grp;
  logic [VW-1:0] vl_eff, vm1;
  logic [GW-1:0] last_grp;

  assign vl_eff   = (vl > VW'(MAXVL)) ? VW'(MAXVL) : vl;
  assign vm1      = vl_q - VW'(1);
  assign last_grp = GW'(vm1 >> LB);
  assign accept   = start && !busy && !s1_vld;
  assign zero_acc = accept && (vl == '0);
  assign rd_en    = busy;
  assign rd_grp   = grp;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      grp     <= '0;
      vl_q    <= '0;
      s1_vld  <= 1'b0;
      s1_grp  <= '0;
      s1_last <= 1'b0;
    end else begin
      s1_vld  <= busy;
      s1_grp  <= grp;
      s1_last <= busy && (grp == last_grp);
      if (accept) begin
        vl_q <= vl_eff;
        grp  <= '0;
        busy <= (vl_eff != '0);
      end else if (busy) begin
        grp <= grp + GW'(1);
        if (grp == last_grp) busy <= 1'b0;
      end
    end
  end

  AST_GRP_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    busy |-> (grp <= last_grp)); // R9
  AST_READ_CONSEC: assert property (@(posedge clk) disable iff (rst)
    (busy && !$rose(busy)) |-> (grp == $past(grp) + GW'(1))); // R9
endmodule

// File: rtl/vlalu_lane.sv
// One lane: operand select, arithmetic, compare and write-enable decision.
module vlalu_lane
  import vlalu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] sca,
  input  logic [2:0]   op,
  input  logic         active,
  input  logic         mbit,
  input  logic         use_mask,
  output logic [W-1:0] res,
  output logic         we,
  output logic         mwe,
  output logic         ne
);
  logic [W-1:0] opb;
  fn_e          fn;

  always_comb begin
    fn  = fn_e'(op[2:1]);
    opb = op[0] ? sca : b;
    ne  = (a != opb);
    case (fn)
      FN_ADD:  res = a + opb;
      FN_SUB:  res = a - opb;
      FN_MUL:  res = a * opb;
      default: res = '0;
    endcase
    we  = active && (fn != FN_CNE) && (!use_mask || mbit);
    mwe = active && (fn == FN_CNE);
  end
endmodule

// File: rtl/vlalu_mask.sv
// Per-element mask register with one read and one update group per cycle.
module vlalu_mask #(
  parameter int LANES = 4,
  parameter int MAXVL = 64,
  localparam int NG = MAXVL / LANES,
  localparam int GW = (NG > 1) ? $clog2(NG) : 1,
  localparam int LB = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [GW-1:0]    grp,
  input  logic [LANES-1:0] upd,
  input  logic [LANES-1:0] val,
  output logic [LANES-1:0] mbits,
  output logic [MAXVL-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
    end else begin
      for (int l = 0; l < LANES; l++)
        if (upd[l]) mask_q[{grp, LB'(l)}] <= val[l];
    end
  end

  always_comb
    for (int l = 0; l < LANES; l++) mbits[l] = mask_q[{grp, LB'(l)}];
endmodule

// File: rtl/vec_lane_alu.sv
module vec_lane_alu
  import vlalu_pkg::*;
#(
  parameter int LANES = 4,
  parameter int MAXVL = 64,
  parameter int W = 32,
  localparam int NG = MAXVL / LANES,
  localparam int GW = (NG > 1) ? $clog2(NG) : 1,
  localparam int LB = $clog2(LANES),
  localparam int VW = $clog2(MAXVL + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [2:0]         op,
  input  logic [VW-1:0]      vl,
  input  logic [W-1:0]       scalar,
  input  logic               use_mask,
  output logic               rd_en,
  output logic [GW-1:0]      rd_grp,
  input  logic [LANES*W-1:0] rd_a,
  input  logic [LANES*W-1:0] rd_b,
  output logic               wr_en,
  output logic [GW-1:0]      wr_grp,
  output logic [LANES*W-1:0] wr_data,
  output logic [LANES-1:0]   wr_be,
  output logic [MAXVL-1:0]   mask_o,
  output logic               done
);
  logic          accept, zero_acc, s1_vld, s1_last;
  logic [VW-1:0] vl_q;
  logic [GW-1:0] s1_grp;
  logic [2:0]    op_q;
  logic [W-1:0]  sca_q;
  logic          um_q;
  logic          is_cmp;
  logic [LANES-1:0]   we, mwe, ne, mbits;
  logic [LANES*W-1:0] res;

  vlalu_seq #(.LANES(LANES), .MAXVL(MAXVL)) u_seq (
    .clk(clk), .rst(rst), .start(start), .vl(vl),
    .accept(accept), .zero_acc(zero_acc), .vl_q(vl_q),
    .rd_en(rd_en), .rd_grp(rd_grp),
    .s1_vld(s1_vld), .s1_grp(s1_grp), .s1_last(s1_last)
  );

  vlalu_mask #(.LANES(LANES), .MAXVL(MAXVL)) u_mask (
    .clk(clk), .rst(rst), .grp(s1_grp),
    .upd(s1_vld ? mwe : '0), .val(ne),
    .mbits(mbits), .mask_q(mask_o)
  );

  assign is_cmp = (fn_e'(op_q[2:1]) == FN_CNE);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic active;
    assign active = VW'({s1_grp, LB'(l)}) < vl_q;

    vlalu_lane #(.W(W)) u_lane (
      .a(rd_a[l*W +: W]), .b(rd_b[l*W +: W]), .sca(sca_q), .op(op_q),
      .active(active), .mbit(mbits[l]), .use_mask(um_q),
      .res(res[l*W +: W]), .we(we[l]), .mwe(mwe[l]), .ne(ne[l])
    );

    AST_BE_INSIDE_VL: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_be[l]) |-> (VW'({wr_grp, LB'(l)}) < vl_q)); // R4
    AST_MASK_GATES: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_be[l] && um_q) |-> mask_o[{wr_grp, LB'(l)}]); // R8
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q    <= '0;
      sca_q   <= '0;
      um_q    <= 1'b0;
      wr_en   <= 1'b0;
      wr_grp  <= '0;
      wr_data <= '0;
      wr_be   <= '0;
      done    <= 1'b0;
    end else begin
      if (accept) begin
        op_q  <= op;
        sca_q <= scalar;
        um_q  <= use_mask;
      end
      wr_en   <= s1_vld && !is_cmp;
      wr_grp  <= s1_grp;
      wr_data <= res;
      wr_be   <= (s1_vld && !is_cmp) ? we : '0;
      done    <= zero_acc || (s1_vld && s1_last);
    end
  end

  AST_CMP_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (fn_e'(op_q[2:1]) != FN_CNE)); // R7
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && s1_last) |=> done); // R3
endmodule

// File: tb/vec_lane_alu_test.sv
module vec_lane_alu_test;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [2:0]   op = '0;
  logic [6:0]   vl = '0;
  logic [31:0]  scalar = '0;
  logic         use_mask = 1'b0;
  logic         rd_en, wr_en, done;
  logic [3:0]   rd_grp, wr_grp;
  logic [127:0] rd_a = '0, rd_b = '0, wr_data;
  logic [3:0]   wr_be;
  logic [63:0]  mask_o;

  int total = 0;
  int bad = 0;

  logic [31:0] A [64];
  logic [31:0] B [64];
  logic [31:0] D [64];
  logic [31:0] E [64];
  logic [63:0] em;
  int wcnt, rd_exp;
  bit rd_bad;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_lane_alu uut (
    .clk(clk), .rst(rst), .start(start), .op(op), .vl(vl), .scalar(scalar),
    .use_mask(use_mask), .rd_en(rd_en), .rd_grp(rd_grp), .rd_a(rd_a), .rd_b(rd_b),
    .wr_en(wr_en), .wr_grp(wr_grp), .wr_data(wr_data), .wr_be(wr_be),
    .mask_o(mask_o), .done(done)
  );

  // source storage (one-cycle read latency) and destination storage
  always @(posedge clk) begin
    if (rd_en) begin
      if (int'(rd_grp) != rd_exp) rd_bad = 1'b1;
      rd_exp = rd_exp + 1;
      for (int l = 0; l < 4; l++) begin
        rd_a[l*32 +: 32] <= A[int'(rd_grp)*4 + l];
        rd_b[l*32 +: 32] <= B[int'(rd_grp)*4 + l];
      end
    end
    if (wr_en) begin
      wcnt = wcnt + 1;
      for (int l = 0; l < 4; l++)
        if (wr_be[l]) D[int'(wr_grp)*4 + l] = wr_data[l*32 +: 32];
    end
  end

  task automatic check(input bit ok, input string msg, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", msg, act, exp);
    end
  endtask

  function automatic logic [31:0] arith(input int fn, input logic [31:0] a, input logic [31:0] b);
    case (fn)
      0: return a + b;
      1: return a - b;
      default: return a * b;
    endcase
  endfunction

  task automatic run_op(input int opc, input int len, input bit um);
    int eff, ng, k, fn, miss, first;
    logic [31:0] sb;
    @(negedge clk);
    eff = (len > 64) ? 64 : len;
    ng = (eff + 3) / 4;
    fn = opc >> 1;
    for (int i = 0; i < 64; i++) begin
      D[i] = 32'hDEAD_0000 | i;
      E[i] = D[i];
    end
    for (int i = 0; i < eff; i++) begin
      sb = opc[0] ? scalar : B[i];
      if (fn == 3) em[i] = (A[i] != sb);
      else if (!um || em[i]) E[i] = arith(fn, A[i], sb);
    end
    wcnt = 0; rd_exp = 0; rd_bad = 1'b0;
    op = opc[2:0]; vl = len[6:0]; use_mask = um; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    k = 0;
    while (!done && k < 400) begin
      @(posedge clk);
      @(negedge clk);
      k++;
    end
    check(k == ((eff == 0) ? 0 : ng + 1), $sformatf("R3 done timing op=%0d vl=%0d", opc, len), 64'(k), 64'((eff == 0) ? 0 : ng + 1));
    @(posedge clk);
    @(negedge clk);
    check(wcnt == ((fn == 3) ? 0 : ng), $sformatf("R3 R4 R7 write count op=%0d vl=%0d", opc, len), 64'(wcnt), 64'((fn == 3) ? 0 : ng));
    check(!rd_bad && rd_exp == ng, $sformatf("R9 read sequence op=%0d vl=%0d", opc, len), 64'(rd_exp), 64'(ng));
    miss = 0; first = 0;
    for (int i = 63; i >= 0; i--)
      if (D[i] !== E[i]) begin miss++; first = i; end
    check(miss == 0, $sformatf("R2 R4 R5 R6 R8 data op=%0d vl=%0d um=%0d elem=%0d", opc, len, um, first),
          64'(D[first]), 64'(E[first]));
    check(mask_o == em, $sformatf("R7 mask op=%0d vl=%0d", opc, len), mask_o, em);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lens [8] = '{0, 1, 3, 4, 5, 63, 64, 100};
    for (int i = 0; i < 64; i++) begin
      A[i] = (32'h0100_0003 * (i + 1)) ^ (i << 20);
      B[i] = (i % 3 == 0) ? A[i] : 32'h7654_3210 + i * 32'h0011_0101;
    end
    scalar = A[9];
    em = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(wr_en == 0 && rd_en == 0 && done == 0, "R1 control outputs after reset",
          64'({wr_en, rd_en, done}), 64'(0));
    check(mask_o == '1, "R1 mask after reset", mask_o, '1);
    for (int v = 0; v < 8; v++)
      for (int o = 0; o < 8; o++)
        for (int m = 0; m < 2; m++)
          run_op(o, lens[v], m[0]);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule